// File: doc/BRIEF.md
# Programmed-I/O Queue Port Front End

This block sits between a simple register bus and the queues of a serial-bus host controller that runs in programmed-I/O mode. Software sees a small set of word addresses. It writes outgoing payload words and command descriptors through two of them. It reads completion records, received payload words and in-band-interrupt records through the others. Toward the transfer engine the block offers plain FIFO ports: pop ports for transmit data and commands, and push ports for receive data, completions and in-band-interrupt records.

One address serves two queues. A write to it goes into the transmit queue, and a read from it takes a word from the receive queue. A 64-bit command descriptor is built from two 32-bit writes by a two-state packer. The packer waits in `CP_LO_WAIT` for the low word. A command-port write moves it to `CP_HI_WAIT`. The next command-port write pushes the whole descriptor, or drops it if the queue is full, and returns the packer to `CP_LO_WAIT`. Reading from an empty queue ends the bus access with an error. A status register combines threshold flags, which are recomputed every cycle from queue occupancy, with sticky overflow flags and flags that software has forced. An enable mask selects which status bits drive the single level interrupt output.

Top module: `pio_qport`

## Requirements
- R1: Every bus request sampled on a clock edge is answered by a one-cycle `rsp_valid` pulse in the following cycle. With no request, `rsp_valid` stays low.
- R2: A write to address 2 puts `reg_wdata` into the transmit queue. The engine sees the words on `tx_data` in write order and removes each one with `tx_pop`.
- R3: A read from address 2 returns the oldest receive-queue word and removes it. If the receive queue is empty, the read returns data 0 with `rsp_err` high and changes nothing.
- R4: A write to address 0 stores the low half of a command. The next write to address 0 pushes `{high, low}` into the command queue. A lone low write pushes nothing, and reset discards any stored half.
- R5: A read from address 1 returns and removes the oldest completion record. An empty completion queue gives data 0 with `rsp_err` high.
- R6: A read from address 3 returns and removes the oldest in-band-interrupt record. An empty queue gives data 0 with `rsp_err` high.
- R7: A data-port write while the transmit queue is full is dropped and sets status bit 4. A high-half command write while the command queue is full is dropped and sets status bit 5.
- R8: Status bits at address 6 are computed live from occupancy. Bit 0 means transmit level <= threshold A4[7:0]. Bit 1 means receive level > A4[15:8]. Bit 2 means completion level >= A5[7:0] and nonzero. Bit 3 means in-band-interrupt level > A5[15:8].
- R9: A write to address 8 sets the written status bits, and they stay set until a write-one-to-clear at address 6. That clear also removes overflow bits but cannot clear a live threshold bit.
- R10: `irq` is high exactly when some status bit is set whose bit in the enable register (address 7) is also set. With all enables at zero, `irq` stays low.
- R11: After reset all queues are empty, threshold and enable registers read 0, status reads 0x1 (only the transmit-level flag), and `irq` is low.
- R12: Threshold registers read back what was written, and reads of unmapped addresses return 0 without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Bus request strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse one cycle after a request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Error response (empty-queue read) |
| tx_pop | input | 1 | Engine takes the transmit head |
| tx_data | output | 32 | Transmit queue head |
| tx_empty | output | 1 | Transmit queue empty |
| cmd_pop | input | 1 | Engine takes the command head |
| cmd_data | output | 64 | Command queue head |
| cmd_empty | output | 1 | Command queue empty |
| rx_push | input | 1 | Engine writes a receive word |
| rx_wdata | input | 32 | Receive word |
| rx_full | output | 1 | Receive queue full |
| resp_push | input | 1 | Engine writes a completion record |
| resp_wdata | input | 32 | Completion record |
| resp_full | output | 1 | Completion queue full |
| ibi_push | input | 1 | Engine writes an in-band-interrupt record |
| ibi_wdata | input | 32 | In-band-interrupt record |
| ibi_full | output | 1 | In-band-interrupt queue full |
| irq | output | 1 | Level interrupt |

## Verification
A read pointer or count that has drifted shows up on the next pop-port read. Either a record comes back out of order, or an error response appears where data is expected. In both cases the fault is visible in the same response that follows the request. A packer stuck in the wrong state shows up when `cmd_data` carries swapped halves, or when the queue fills after only one write. Sticky or forced status bits that fail to clear or set show up on the very next status read and on `irq` within one cycle.

// File: rtl/pio_qport_pkg.sv
package pio_qport_pkg;
    localparam int AW    = 4;
    localparam int DW    = 32;
    localparam int LVW   = 8;
    localparam int NSTAT = 6;

    localparam logic [AW-1:0] A_CMD    = 4'd0;
    localparam logic [AW-1:0] A_RESP   = 4'd1;
    localparam logic [AW-1:0] A_DATA   = 4'd2;
    localparam logic [AW-1:0] A_IBI    = 4'd3;
    localparam logic [AW-1:0] A_BUFLVL = 4'd4;
    localparam logic [AW-1:0] A_QLVL   = 4'd5;
    localparam logic [AW-1:0] A_STAT   = 4'd6;
    localparam logic [AW-1:0] A_EN     = 4'd7;
    localparam logic [AW-1:0] A_FORCE  = 4'd8;

    localparam int S_TX     = 0;
    localparam int S_RX     = 1;
    localparam int S_RSP    = 2;
    localparam int S_IBI    = 3;
    localparam int S_TXOVF  = 4;
    localparam int S_CMDOVF = 5;

    typedef enum logic {CP_LO_WAIT, CP_HI_WAIT} cp_state_e;
endpackage

// File: rtl/qp_fifo.sv
module qp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int LVW   = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [W-1:0]   wdata,
    output logic           full,
    input  logic           pop,
    output logic [W-1:0]   rdata,
    output logic           empty,
    output logic [LVW-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];
    assign level   = LVW'(cnt);

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/qp_cmd_pack.sv
module qp_cmd_pack
    import pio_qport_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [DW-1:0]   wdata,
    input  logic            full,
    output logic            push,
    output logic [2*DW-1:0] pdata,
    output logic            ovf,
    output logic            hi_pending
);
    cp_state_e     state, nxt;
    logic [DW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CP_LO_WAIT;
            lo_q  <= '0;
        end else begin
            state <= nxt;
            if (wr_stb && state == CP_LO_WAIT) lo_q <= wdata;
        end
    end

    always_comb begin
        nxt        = state;
        push       = 1'b0;
        ovf        = 1'b0;
        hi_pending = 1'b0;
        pdata      = {wdata, lo_q};
        unique case (state)
            CP_LO_WAIT: begin
                if (wr_stb) nxt = CP_HI_WAIT;
            end
            CP_HI_WAIT: begin
                hi_pending = 1'b1;
                if (wr_stb) begin
                    nxt  = CP_LO_WAIT;
                    push = !full;
                    ovf  = full;
                end
            end
            default: nxt = CP_LO_WAIT;
        endcase
    end
endmodule

// File: rtl/qp_irq.sv
module qp_irq
    import pio_qport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVW-1:0]   tx_thr,
    input  logic [LVW-1:0]   rx_thr,
    input  logic [LVW-1:0]   rsp_thr,
    input  logic [LVW-1:0]   ibi_thr,
    input  logic [LVW-1:0]   tx_level,
    input  logic [LVW-1:0]   rx_level,
    input  logic [LVW-1:0]   rsp_level,
    input  logic [LVW-1:0]   ibi_level,
    input  logic             tx_ovf_ev,
    input  logic             cmd_ovf_ev,
    input  logic             force_stb,
    input  logic             w1c_stb,
    input  logic [NSTAT-1:0] wbits,
    input  logic [NSTAT-1:0] en,
    output logic [NSTAT-1:0] stat,
    output logic             irq
);
    logic [NSTAT-1:0] live, held, set_m, clr_m;

    always_comb begin
        live         = '0;
        live[S_TX]   = (tx_level <= tx_thr);
        live[S_RX]   = (rx_level > rx_thr);
        live[S_RSP]  = (rsp_level != '0) && (rsp_level >= rsp_thr);
        live[S_IBI]  = (ibi_level > ibi_thr);
    end

    always_comb begin
        set_m            = force_stb ? wbits : '0;
        set_m[S_TXOVF]   = set_m[S_TXOVF] | tx_ovf_ev;
        set_m[S_CMDOVF]  = set_m[S_CMDOVF] | cmd_ovf_ev;
        clr_m            = w1c_stb ? wbits : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= (held & ~clr_m) | set_m;
    end

    assign stat = live | held;
    assign irq  = |(stat & en);
endmodule

// File: rtl/pio_qport.sv
module pio_qport
    import pio_qport_pkg::*;
#(
    parameter int TX_DEPTH   = 8,
    parameter int RX_DEPTH   = 8,
    parameter int CMD_DEPTH  = 4,
    parameter int RESP_DEPTH = 4,
    parameter int IBI_DEPTH  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_req,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          rsp_err,
    input  logic          tx_pop,
    output logic [31:0]   tx_data,
    output logic          tx_empty,
    input  logic          cmd_pop,
    output logic [63:0]   cmd_data,
    output logic          cmd_empty,
    input  logic          rx_push,
    input  logic [31:0]   rx_wdata,
    output logic          rx_full,
    input  logic          resp_push,
    input  logic [31:0]   resp_wdata,
    output logic          resp_full,
    input  logic          ibi_push,
    input  logic [31:0]   ibi_wdata,
    output logic          ibi_full,
    output logic          irq
);
    localparam int TW = 2 * LVW;

    logic wr_q, rd_q;
    logic wr_data, wr_cmd, rd_data, rd_resp, rd_ibi;
    logic wr_buflvl, wr_qlvl, wr_stat, wr_en, wr_force;

    logic tx_full_w, cmd_full_w, rx_empty_w, resp_empty_w, ibi_empty_w;
    logic [LVW-1:0] tx_level_w, rx_level_w, resp_level_w, ibi_level_w, cmd_level_w;
    logic [DW-1:0]  rx_head, resp_head, ibi_head;

    logic            cmd_push_w, cmd_ovf_w, cmd_hi_pend_w;
    logic [2*DW-1:0] cmd_pdata;

    logic [TW-1:0]    buf_lvl_q, q_lvl_q;
    logic [NSTAT-1:0] en_q, stat_w;

    logic [DW-1:0] rd_val;
    logic          rd_err;

    assign wr_q      = reg_req && reg_wr;
    assign rd_q      = reg_req && !reg_wr;
    assign wr_data   = wr_q && (reg_addr == A_DATA);
    assign wr_cmd    = wr_q && (reg_addr == A_CMD);
    assign wr_buflvl = wr_q && (reg_addr == A_BUFLVL);
    assign wr_qlvl   = wr_q && (reg_addr == A_QLVL);
    assign wr_stat   = wr_q && (reg_addr == A_STAT);
    assign wr_en     = wr_q && (reg_addr == A_EN);
    assign wr_force  = wr_q && (reg_addr == A_FORCE);
    assign rd_data   = rd_q && (reg_addr == A_DATA);
    assign rd_resp   = rd_q && (reg_addr == A_RESP);
    assign rd_ibi    = rd_q && (reg_addr == A_IBI);

    qp_fifo #(.W(DW), .DEPTH(TX_DEPTH), .LVW(LVW)) u_tx (
        .clk(clk), .rst_n(rst_n), .push(wr_data), .wdata(reg_wdata), .full(tx_full_w),
        .pop(tx_pop), .rdata(tx_data), .empty(tx_empty), .level(tx_level_w));

    qp_fifo #(.W(DW), .DEPTH(RX_DEPTH), .LVW(LVW)) u_rx (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata), .full(rx_full),
        .pop(rd_data), .rdata(rx_head), .empty(rx_empty_w), .level(rx_level_w));

    qp_fifo #(.W(DW), .DEPTH(RESP_DEPTH), .LVW(LVW)) u_resp (
        .clk(clk), .rst_n(rst_n), .push(resp_push), .wdata(resp_wdata), .full(resp_full),
        .pop(rd_resp), .rdata(resp_head), .empty(resp_empty_w), .level(resp_level_w));

    qp_fifo #(.W(DW), .DEPTH(IBI_DEPTH), .LVW(LVW)) u_ibi (
        .clk(clk), .rst_n(rst_n), .push(ibi_push), .wdata(ibi_wdata), .full(ibi_full),
        .pop(rd_ibi), .rdata(ibi_head), .empty(ibi_empty_w), .level(ibi_level_w));

    qp_fifo #(.W(2*DW), .DEPTH(CMD_DEPTH), .LVW(LVW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .push(cmd_push_w), .wdata(cmd_pdata), .full(cmd_full_w),
        .pop(cmd_pop), .rdata(cmd_data), .empty(cmd_empty), .level(cmd_level_w));

    qp_cmd_pack u_pack (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_cmd), .wdata(reg_wdata), .full(cmd_full_w),
        .push(cmd_push_w), .pdata(cmd_pdata), .ovf(cmd_ovf_w), .hi_pending(cmd_hi_pend_w));

    qp_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_thr(buf_lvl_q[LVW-1:0]), .rx_thr(buf_lvl_q[TW-1:LVW]),
        .rsp_thr(q_lvl_q[LVW-1:0]),  .ibi_thr(q_lvl_q[TW-1:LVW]),
        .tx_level(tx_level_w), .rx_level(rx_level_w),
        .rsp_level(resp_level_w), .ibi_level(ibi_level_w),
        .tx_ovf_ev(wr_data && tx_full_w), .cmd_ovf_ev(cmd_ovf_w),
        .force_stb(wr_force), .w1c_stb(wr_stat), .wbits(reg_wdata[NSTAT-1:0]),
        .en(en_q), .stat(stat_w), .irq(irq));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_lvl_q <= '0;
            q_lvl_q   <= '0;
            en_q      <= '0;
        end else begin
            if (wr_buflvl) buf_lvl_q <= reg_wdata[TW-1:0];
            if (wr_qlvl)   q_lvl_q   <= reg_wdata[TW-1:0];
            if (wr_en)     en_q      <= reg_wdata[NSTAT-1:0];
        end
    end

    always_comb begin
        rd_val = '0;
        rd_err = 1'b0;
        if (rd_q) begin
            unique case (reg_addr)
                A_DATA: begin
                    rd_err = rx_empty_w;
                    rd_val = rx_empty_w ? '0 : rx_head;
                end
                A_RESP: begin
                    rd_err = resp_empty_w;
                    rd_val = resp_empty_w ? '0 : resp_head;
                end
                A_IBI: begin
                    rd_err = ibi_empty_w;
                    rd_val = ibi_empty_w ? '0 : ibi_head;
                end
                A_BUFLVL: rd_val = DW'(buf_lvl_q);
                A_QLVL:   rd_val = DW'(q_lvl_q);
                A_STAT:   rd_val = DW'(stat_w);
                A_EN:     rd_val = DW'(en_q);
                default:  rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= reg_req;
            rsp_rdata <= rd_val;
            rsp_err   <= rd_err;
        end
    end
endmodule

// File: rtl/pio_qport_chk.sv
module pio_qport_chk
    import pio_qport_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_req,
    input logic             reg_wr,
    input logic [AW-1:0]    reg_addr,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic             rx_empty_w,
    input logic             resp_empty_w,
    input logic             tx_full_w,
    input logic             tx_pop,
    input logic [LVW-1:0]   tx_level_w,
    input logic [NSTAT-1:0] stat_w,
    input logic             cmd_push_w,
    input logic             cmd_hi_pend_w,
    input logic [NSTAT-1:0] en_q,
    input logic             irq
);
    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> rsp_valid);

    p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_req |=> !rsp_valid);

    p_rx_empty_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_wr && reg_addr == A_DATA && rx_empty_w) |=> rsp_err);

    p_resp_empty_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_wr && reg_addr == A_RESP && resp_empty_w) |=> rsp_err);

    p_cmd_needs_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push_w |-> cmd_hi_pend_w);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_wr && reg_addr == A_DATA && tx_full_w && !tx_pop)
        |=> (tx_level_w == $past(tx_level_w)) && stat_w[S_TXOVF]);

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

bind pio_qport pio_qport_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rx_empty_w(rx_empty_w),
    .resp_empty_w(resp_empty_w), .tx_full_w(tx_full_w), .tx_pop(tx_pop),
    .tx_level_w(tx_level_w), .stat_w(stat_w), .cmd_push_w(cmd_push_w),
    .cmd_hi_pend_w(cmd_hi_pend_w), .en_q(en_q), .irq(irq));

// File: tb/pio_qport_test.sv
module pio_qport_test;
    localparam int CLK_NS = 10;
    localparam int TXD    = 8;
    localparam int CMDD   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 0, reg_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        tx_pop = 0, cmd_pop = 0;
    logic [31:0] tx_data;
    logic [63:0] cmd_data;
    logic        tx_empty, cmd_empty;
    logic        rx_push = 0, resp_push = 0, ibi_push = 0;
    logic [31:0] rx_wdata = 0, resp_wdata = 0, ibi_wdata = 0;
    logic        rx_full, resp_full, ibi_full, irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_NS/2) clk = ~clk;

    pio_qport #(.TX_DEPTH(TXD), .CMD_DEPTH(CMDD)) uut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
        .cmd_pop(cmd_pop), .cmd_data(cmd_data), .cmd_empty(cmd_empty),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_full(rx_full),
        .resp_push(resp_push), .resp_wdata(resp_wdata), .resp_full(resp_full),
        .ibi_push(ibi_push), .ibi_wdata(ibi_wdata), .ibi_full(ibi_full), .irq(irq));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [3:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        reg_req = 1; reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 0; reg_wr = 0;
        rd = rsp_rdata; er = rsp_err;
        check("R1 rsp_valid pulse", 64'(rsp_valid), 64'd1);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] v; logic e;
        bus(1'b1, a, d, v, e);
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] xd, input logic xe);
        logic [31:0] v; logic e;
        bus(1'b0, a, 32'd0, v, e);
        check({tag, " data"}, 64'(v), 64'(xd));
        check({tag, " err"}, 64'(e), 64'(xe));
    endtask

    task automatic eng(input int q, input logic [31:0] d);
        @(negedge clk);
        case (q)
            0: begin rx_push = 1; rx_wdata = d; end
            1: begin resp_push = 1; resp_wdata = d; end
            default: begin ibi_push = 1; ibi_wdata = d; end
        endcase
        @(negedge clk);
        rx_push = 0; resp_push = 0; ibi_push = 0;
    endtask

    task automatic pop_tx(input string tag, input logic [31:0] x);
        check({tag, " tx not empty"}, 64'(tx_empty), 64'd0);
        check({tag, " tx head"}, 64'(tx_data), 64'(x));
        @(negedge clk); tx_pop = 1;
        @(negedge clk); tx_pop = 0;
    endtask

    task automatic pop_cmd(input string tag, input logic [63:0] x);
        check({tag, " cmd not empty"}, 64'(cmd_empty), 64'd0);
        check({tag, " cmd head"}, cmd_data, x);
        @(negedge clk); cmd_pop = 1;
        @(negedge clk); cmd_pop = 0;
    endtask

    task automatic t_reset;
        check("R11 irq low", 64'(irq), 64'd0);
        check("R11 tx empty", 64'(tx_empty), 64'd1);
        check("R11 cmd empty", 64'(cmd_empty), 64'd1);
        rd("R11 status", 4'd6, 32'h1, 1'b0);
        rd("R11 buf lvl", 4'd4, 32'h0, 1'b0);
        rd("R11 enable", 4'd7, 32'h0, 1'b0);
        rd("R12 unmapped", 4'd15, 32'h0, 1'b0);
        @(negedge clk);
        check("R1 idle no rsp", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_tx;
        wr(4'd2, 32'hA1); wr(4'd2, 32'hA2); wr(4'd2, 32'hA3);
        pop_tx("R2 w0", 32'hA1);
        pop_tx("R2 w1", 32'hA2);
        pop_tx("R2 w2", 32'hA3);
        check("R2 drained", 64'(tx_empty), 64'd1);
    endtask

    task automatic t_rx;
        rd("R3 empty read", 4'd2, 32'h0, 1'b1);
        eng(0, 32'hB1); eng(0, 32'hB2);
        rd("R3 word0", 4'd2, 32'hB1, 1'b0);
        rd("R3 word1", 4'd2, 32'hB2, 1'b0);
        rd("R3 empty again", 4'd2, 32'h0, 1'b1);
    endtask

    task automatic t_cmd;
        wr(4'd0, 32'hC0C0_0000);
        check("R4 low alone no push", 64'(cmd_empty), 64'd1);
        wr(4'd0, 32'h0000_C1C1);
        pop_cmd("R4 packed", 64'h0000_C1C1_C0C0_0000);
        check("R4 drained", 64'(cmd_empty), 64'd1);
    endtask

    task automatic t_resp_ibi;
        rd("R5 empty", 4'd1, 32'h0, 1'b1);
        eng(1, 32'hD1); eng(1, 32'hD2);
        rd("R5 rec0", 4'd1, 32'hD1, 1'b0);
        rd("R5 rec1", 4'd1, 32'hD2, 1'b0);
        rd("R5 empty again", 4'd1, 32'h0, 1'b1);
        rd("R6 empty", 4'd3, 32'h0, 1'b1);
        eng(2, 32'hE1);
        rd("R6 rec0", 4'd3, 32'hE1, 1'b0);
        rd("R6 empty again", 4'd3, 32'h0, 1'b1);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < TXD; i++) wr(4'd2, 32'h100 + 32'(i));
        rd("R7 no ovf yet", 4'd6, 32'h0, 1'b0);
        wr(4'd2, 32'hDEAD);
        rd("R7 tx ovf bit", 4'd6, 32'h10, 1'b0);
        for (int i = 0; i < TXD; i++) pop_tx("R7 kept", 32'h100 + 32'(i));
        check("R7 extra dropped", 64'(tx_empty), 64'd1);
        for (int i = 0; i < CMDD; i++) begin
            wr(4'd0, 32'(i)); wr(4'd0, 32'h200 + 32'(i));
        end
        wr(4'd0, 32'h55); wr(4'd0, 32'h66);
        rd("R7 cmd ovf bit", 4'd6, 32'h31, 1'b0);
        for (int i = 0; i < CMDD; i++) pop_cmd("R7 cmd kept", {32'h200 + 32'(i), 32'(i)});
        check("R7 cmd dropped", 64'(cmd_empty), 64'd1);
        wr(4'd6, 32'h30);
        rd("R9 w1c overflow", 4'd6, 32'h1, 1'b0);
    endtask

    task automatic t_thresh;
        wr(4'd4, 32'h0102);
        rd("R12 buf lvl readback", 4'd4, 32'h0102, 1'b0);
        wr(4'd2, 32'h1); wr(4'd2, 32'h2);
        rd("R8 tx at thr", 4'd6, 32'h1, 1'b0);
        wr(4'd2, 32'h3);
        rd("R8 tx above thr", 4'd6, 32'h0, 1'b0);
        eng(0, 32'h11);
        rd("R8 rx at thr", 4'd6, 32'h0, 1'b0);
        eng(0, 32'h12);
        rd("R8 rx above thr", 4'd6, 32'h2, 1'b0);
        wr(4'd5, 32'h0002);
        rd("R12 q lvl readback", 4'd5, 32'h0002, 1'b0);
        eng(1, 32'h21);
        rd("R8 resp below", 4'd6, 32'h2, 1'b0);
        eng(1, 32'h22);
        rd("R8 resp reached", 4'd6, 32'h6, 1'b0);
        eng(2, 32'h31);
        rd("R8 ibi above", 4'd6, 32'hE, 1'b0);
        pop_tx("R8 cleanup", 32'h1); pop_tx("R8 cleanup", 32'h2); pop_tx("R8 cleanup", 32'h3);
        rd("R8 cleanup rx", 4'd2, 32'h11, 1'b0);
        rd("R8 cleanup rx", 4'd2, 32'h12, 1'b0);
        rd("R8 cleanup resp", 4'd1, 32'h21, 1'b0);
        rd("R8 cleanup resp", 4'd1, 32'h22, 1'b0);
        rd("R8 cleanup ibi", 4'd3, 32'h31, 1'b0);
        wr(4'd4, 32'h0); wr(4'd5, 32'h0);
        rd("R8 back to idle", 4'd6, 32'h1, 1'b0);
    endtask

    task automatic t_force_irq;
        wr(4'd8, 32'h8);
        rd("R9 forced set", 4'd6, 32'h9, 1'b0);
        repeat (5) @(negedge clk);
        rd("R9 forced held", 4'd6, 32'h9, 1'b0);
        check("R10 masked", 64'(irq), 64'd0);
        wr(4'd7, 32'h8);
        check("R10 enabled", 64'(irq), 64'd1);
        wr(4'd6, 32'h9);
        rd("R9 w1c keeps live", 4'd6, 32'h1, 1'b0);
        check("R10 cleared", 64'(irq), 64'd0);
        wr(4'd7, 32'h1);
        check("R10 live bit", 64'(irq), 64'd1);
        wr(4'd7, 32'h0);
        check("R10 disabled", 64'(irq), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_tx();
        t_rx();
        t_cmd();
        t_resp_ibi();
        t_overflow();
        t_thresh();
        t_force_irq();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule